// File: doc/BRIEF.md
# Host I/O to Z80-Family Peripheral Bus Bridge

This block sits between a host processor that has its own I/O space and one or two Z80-family counter/timer chips. The host presents an address, write data and one of three level strobes (I/O read, I/O write, interrupt acknowledge). It holds the strobe until the bridge answers with a one-cycle ready pulse. On the peripheral side the bridge produces active-low IORQ, RD and M1, one active-low chip enable per chip, a two-bit channel select, and a driven data bus with an output enable. Every mapped access is stretched by a fixed number of wait states. A parameter sets that number together with the chip count.

Peripheral channel registers occupy one host address each, starting at 210h. There are four channels per chip, so one chip covers 210h–213h and a second chip covers 214h–217h. The host's interrupt acknowledge becomes an M1-with-IORQ vector read, and the vector is handed back to the host. The peripheral only releases its interrupt daisy chain when it sees a return-from-interrupt opcode fetch, which the host never issues. To produce it, every host write to port 260h is replayed as an opcode-fetch cycle carrying the written byte. Writing EDh and then 4Dh therefore looks to the peripheral like the two-byte return opcode.

Top module: `hostPeriphBridge`

## Requirements
- R1: After reset, and whenever no access is in progress, perIorqN, perRdN, perM1N and every bit of perCeN are 1, perDataOe is 0 and hostReady is 0. hostRdData resets to 00h.
- R2: A read or write to address 210h + 4*i + c selects chip i (i < NUM_CHIPS), with c in 0..3. Only perCeN[i] goes low, and perChanSel equals c. Any other address, except a write to 260h, makes no peripheral cycle. It completes with hostReady one clock edge after the strobe is sampled, and an unmapped read returns FFh.
- R3: A mapped read holds perIorqN=0, perRdN=0, perM1N=1 for WAITS+1 cycles. The byte on perDataIn in the last of those cycles appears on hostRdData.
- R4: A mapped write holds perIorqN=0, perRdN=1, perM1N=1 and perDataOe=1 with the host byte on perDataOut for WAITS+1 cycles, so the selected channel stores that byte.
- R5: An interrupt acknowledge holds perM1N=0 and perIorqN=0 with perRdN=1 and no chip enable for WAITS+1 cycles. The vector on perDataIn is returned on hostRdData.
- R6: hostReady is high for exactly one cycle, WAITS+2 clock edges after the edge that first samples a mapped strobe. WAITS is 3 when NUM_CHIPS is 1 and 15 when NUM_CHIPS is 2.
- R7: A write to 260h produces one opcode-fetch cycle: perM1N=0, perRdN=0, perIorqN=1, no chip enable, perDataOe=1 with the written byte on perDataOut.
- R8: The peripheral sees a return-from-interrupt exactly once for each write pair EDh then 4Dh to 260h. A 4Dh not directly preceded by EDh, or an EDh followed by another byte, gives plain fetches only.
- R9: A strobe still held after its ready pulse starts no second access. The next access begins only after the strobe has been low for at least one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostAddr | input | ADDR_W | Host I/O address |
| hostWrData | input | 8 | Host write data |
| hostRd | input | 1 | Host I/O read strobe, held until ready |
| hostWr | input | 1 | Host I/O write strobe, held until ready |
| hostIntAck | input | 1 | Host interrupt acknowledge strobe, held until ready |
| hostReady | output | 1 | One-cycle completion pulse |
| hostRdData | output | 8 | Data of the last read or acknowledge |
| perChanSel | output | 2 | Channel select within the chip |
| perCeN | output | NUM_CHIPS | Active-low chip enables |
| perIorqN | output | 1 | Active-low I/O request |
| perRdN | output | 1 | Active-low read |
| perM1N | output | 1 | Active-low opcode-fetch marker |
| perDataOut | output | 8 | Data driven toward the peripheral |
| perDataOe | output | 1 | Drive enable for perDataOut |
| perDataIn | input | 8 | Data driven by the peripheral |

## Verification
The hardest case to reach from the ports is the peripheral's view of the return opcode. It depends on the order of several separate host writes to 260h, not on any single access. The stimulus sends the clean EDh/4Dh pair, a lone 4Dh, and EDh followed by an unrelated byte and then 4Dh. A behavioural peripheral model counts detected returns, so the count must rise exactly once. A second instance built with two chips exercises the long wait count and the upper chip enable. A read whose strobe is held well past its ready pulse shows that no second cycle is started.

// File: rtl/hpb_pkg.sv
package hpb_pkg;

  typedef enum logic [2:0] {
    K_RD      = 3'd0,
    K_WR      = 3'd1,
    K_ACK     = 3'd2,
    K_FETCH   = 3'd3,
    K_MISS_RD = 3'd4,
    K_MISS_WR = 3'd5
  } kind_e;

  typedef struct packed {
    logic  latch;
    logic  active;
    logic  capture;
    kind_e kind;
  } ctrl_s;

endpackage

// File: rtl/hpbControl.sv
module hpbControl
  import hpb_pkg::*;
#(
  parameter int unsigned WAITS = 3
) (
  input  logic  clk,
  input  logic  rstN,
  input  logic  hostRd,
  input  logic  hostWr,
  input  logic  hostIntAck,
  input  logic  addrHit,
  input  logic  retiPortHit,
  output ctrl_s ctrl,
  output logic  hostReady
);

  localparam int unsigned CW = (WAITS > 0) ? $clog2(WAITS + 1) : 1;

  typedef enum logic [1:0] {S_IDLE, S_ACT, S_DONE, S_HOLD} state_e;

  state_e        state;
  kind_e         kindQ;
  kind_e         nextKind;
  logic [CW-1:0] cnt;
  logic          anyStrobe;
  logic          lastWait;

  assign anyStrobe = hostRd | hostWr | hostIntAck;
  assign lastWait  = (cnt == CW'(WAITS));

  always_comb begin
    if (hostIntAck)  nextKind = K_ACK;
    else if (hostRd) nextKind = addrHit ? K_RD : K_MISS_RD;
    else if (addrHit)     nextKind = K_WR;
    else if (retiPortHit) nextKind = K_FETCH;
    else                  nextKind = K_MISS_WR;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      kindQ <= K_MISS_WR;
      cnt   <= '0;
    end else begin
      case (state)
        S_IDLE: if (anyStrobe) begin
          kindQ <= nextKind;
          cnt   <= '0;
          state <= (nextKind == K_MISS_RD || nextKind == K_MISS_WR) ? S_DONE : S_ACT;
        end
        S_ACT: begin
          if (lastWait) state <= S_DONE;
          else          cnt   <= cnt + 1'b1;
        end
        S_DONE: state <= S_HOLD;
        S_HOLD: if (!anyStrobe) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    ctrl.latch   = (state == S_IDLE) && anyStrobe;
    ctrl.active  = (state == S_ACT);
    ctrl.kind    = (state == S_IDLE) ? nextKind : kindQ;
    ctrl.capture = ((state == S_ACT) && lastWait && (kindQ == K_RD || kindQ == K_ACK))
                 || ((state == S_IDLE) && anyStrobe && nextKind == K_MISS_RD);
  end

  assign hostReady = (state == S_DONE);

  AST_READY_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    hostReady |=> !hostReady); // R6

  AST_HOLD_NO_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_HOLD && anyStrobe) |=> !ctrl.active); // R9

  AST_READY_AFTER_WAITS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hostReady) && $past(ctrl.active) |-> $past(cnt) == CW'(WAITS)); // R6

endmodule

// File: rtl/hpbDatapath.sv
module hpbDatapath
  import hpb_pkg::*;
#(
  parameter int unsigned NUM_CHIPS = 1,
  parameter int unsigned ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0210,
  parameter logic [ADDR_W-1:0] RETI_PORT = 16'h0260
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [7:0]        hostWrData,
  input  ctrl_s             ctrl,
  input  logic [7:0]        perDataIn,
  output logic              addrHit,
  output logic              retiPortHit,
  output logic [7:0]        hostRdData,
  output logic [1:0]        perChanSel,
  output logic [NUM_CHIPS-1:0] perCeN,
  output logic              perIorqN,
  output logic              perRdN,
  output logic              perM1N,
  output logic [7:0]        perDataOut,
  output logic              perDataOe
);

  localparam int unsigned CH_PER_CHIP = 4;
  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(CH_PER_CHIP * NUM_CHIPS);

  logic [ADDR_W-1:0] addrQ;
  logic [ADDR_W-1:0] offQ;
  logic [7:0]        dataQ;
  logic              ioKind;

  assign addrHit     = (hostAddr >= BASE_ADDR) && (hostAddr < BASE_ADDR + SPAN);
  assign retiPortHit = (hostAddr == RETI_PORT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ      <= '0;
      dataQ      <= '0;
      hostRdData <= '0;
    end else begin
      if (ctrl.latch) begin
        addrQ <= hostAddr;
        dataQ <= hostWrData;
      end
      if (ctrl.capture)
        hostRdData <= (ctrl.kind == K_MISS_RD) ? 8'hFF : perDataIn;
    end
  end

  assign offQ       = addrQ - BASE_ADDR;
  assign perChanSel = offQ[1:0];
  assign ioKind     = ctrl.active && (ctrl.kind == K_RD || ctrl.kind == K_WR);

  for (genvar i = 0; i < NUM_CHIPS; i++) begin : g_ce
    assign perCeN[i] = !(ioKind && ((offQ >> 2) == ADDR_W'(i)));
  end

  always_comb begin
    perIorqN  = 1'b1;
    perRdN    = 1'b1;
    perM1N    = 1'b1;
    perDataOe = 1'b0;
    if (ctrl.active) begin
      case (ctrl.kind)
        K_RD:    begin perIorqN = 1'b0; perRdN = 1'b0; end
        K_WR:    begin perIorqN = 1'b0; perDataOe = 1'b1; end
        K_ACK:   begin perIorqN = 1'b0; perM1N = 1'b0; end
        K_FETCH: begin perM1N = 1'b0; perRdN = 1'b0; perDataOe = 1'b1; end
        default: ;
      endcase
    end
  end

  assign perDataOut = perDataOe ? dataQ : 8'h00;

  AST_ACK_NO_RD: assert property (@(posedge clk) disable iff (!rstN)
    (!perM1N && !perIorqN) |-> perRdN); // R5

  AST_CE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~perCeN)); // R2

  AST_CE_NEEDS_IORQ: assert property (@(posedge clk) disable iff (!rstN)
    (perCeN != '1) |-> (!perIorqN && perM1N)); // R2

  AST_FETCH_NO_IORQ: assert property (@(posedge clk) disable iff (!rstN)
    (!perM1N && !perRdN) |-> (perIorqN && perDataOe)); // R7

  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.active |-> (perIorqN && perM1N && perRdN && !perDataOe)); // R1

endmodule

// File: rtl/hostPeriphBridge.sv
module hostPeriphBridge
  import hpb_pkg::*;
#(
  parameter int unsigned NUM_CHIPS = 1,
  parameter int unsigned ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0210,
  parameter logic [ADDR_W-1:0] RETI_PORT = 16'h0260
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    hostAddr,
  input  logic [7:0]           hostWrData,
  input  logic                 hostRd,
  input  logic                 hostWr,
  input  logic                 hostIntAck,
  output logic                 hostReady,
  output logic [7:0]           hostRdData,
  output logic [1:0]           perChanSel,
  output logic [NUM_CHIPS-1:0] perCeN,
  output logic                 perIorqN,
  output logic                 perRdN,
  output logic                 perM1N,
  output logic [7:0]           perDataOut,
  output logic                 perDataOe,
  input  logic [7:0]           perDataIn
);

  localparam int unsigned WAITS = (NUM_CHIPS > 1) ? 15 : 3;

  ctrl_s ctrl;
  logic  addrHit;
  logic  retiPortHit;

  hpbControl #(.WAITS(WAITS)) uCtrl (
    .clk(clk), .rstN(rstN),
    .hostRd(hostRd), .hostWr(hostWr), .hostIntAck(hostIntAck),
    .addrHit(addrHit), .retiPortHit(retiPortHit),
    .ctrl(ctrl), .hostReady(hostReady)
  );

  hpbDatapath #(
    .NUM_CHIPS(NUM_CHIPS), .ADDR_W(ADDR_W),
    .BASE_ADDR(BASE_ADDR), .RETI_PORT(RETI_PORT)
  ) uData (
    .clk(clk), .rstN(rstN),
    .hostAddr(hostAddr), .hostWrData(hostWrData),
    .ctrl(ctrl), .perDataIn(perDataIn),
    .addrHit(addrHit), .retiPortHit(retiPortHit),
    .hostRdData(hostRdData), .perChanSel(perChanSel), .perCeN(perCeN),
    .perIorqN(perIorqN), .perRdN(perRdN), .perM1N(perM1N),
    .perDataOut(perDataOut), .perDataOe(perDataOe)
  );

endmodule

// File: tb/hostPeriphBridge_test.sv
`timescale 1ns/1ps
module hostPeriphBridge_test;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rstN = 1'b0;
  logic [15:0] hostAddr = '0;
  logic [7:0]  hostWrData = '0;
  logic        nRd = 0, nWr = 0, nAck = 0;
  logic        wRd = 0;

  logic        nReady, wReady;
  logic [7:0]  nRdData, wRdData;
  logic [1:0]  nChan, wChan;
  logic [0:0]  nCeN;
  logic [1:0]  wCeN;
  logic        nIorqN, nRdN, nM1N, nOe, wIorqN, wRdN, wM1N, wOe;
  logic [7:0]  nDout, wDout, nDin;

  int tests = 0, fails = 0;

  hostPeriphBridge uut (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWrData(hostWrData),
    .hostRd(nRd), .hostWr(nWr), .hostIntAck(nAck),
    .hostReady(nReady), .hostRdData(nRdData), .perChanSel(nChan), .perCeN(nCeN),
    .perIorqN(nIorqN), .perRdN(nRdN), .perM1N(nM1N),
    .perDataOut(nDout), .perDataOe(nOe), .perDataIn(nDin)
  );

  hostPeriphBridge #(.NUM_CHIPS(2)) uutWide (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWrData(hostWrData),
    .hostRd(wRd), .hostWr(1'b0), .hostIntAck(1'b0),
    .hostReady(wReady), .hostRdData(wRdData), .perChanSel(wChan), .perCeN(wCeN),
    .perIorqN(wIorqN), .perRdN(wRdN), .perM1N(wM1N),
    .perDataOut(wDout), .perDataOe(wOe), .perDataIn(8'h5A)
  );

  // Behavioural peripheral model for the one-chip instance
  logic [7:0] regs [4];
  int   iorqRun = 0, iorqLen = 0, busEvents = 0, fetchCount = 0, retiCount = 0;
  logic edSeen = 0, prevM1N = 1, prevIorqN = 1, ackRdBad = 0, ackCeBad = 0;
  logic [7:0] lastFetch = '0;
  logic wCe1Seen = 0, wCe0Seen = 0;

  initial for (int i = 0; i < 4; i++) regs[i] = 8'h00;

  assign nDin = (!nM1N && !nIorqN) ? 8'h1C : regs[nChan];

  always @(posedge clk) begin
    if (!nIorqN) iorqRun++;
    else if (iorqRun != 0) begin iorqLen = iorqRun; iorqRun = 0; end
    if ((!nIorqN && prevIorqN) || (!nM1N && prevM1N)) busEvents++;
    if (!nIorqN && nRdN && nM1N && !nCeN[0]) regs[nChan] = nDout;
    if (!nM1N && !nIorqN) begin
      if (!nRdN) ackRdBad = 1;
      if (!nCeN[0]) ackCeBad = 1;
    end
    if (!nM1N && prevM1N && !nRdN && nIorqN) begin
      fetchCount++;
      lastFetch = nDout;
      if (edSeen && nDout == 8'h4D) retiCount++;
      edSeen = (nDout == 8'hED);
    end
    prevM1N = nM1N;
    prevIorqN = nIorqN;
    if (!wIorqN && !wCeN[1]) wCe1Seen = 1;
    if (!wCeN[0]) wCe0Seen = 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // kind: 0 read, 1 write, 2 interrupt acknowledge
  task automatic access(input int kind, input logic [15:0] a, input logic [7:0] d,
                        input int holdExtra, output int cycles, output int extraReady);
    @(negedge clk);
    hostAddr = a; hostWrData = d;
    case (kind)
      0: nRd = 1;
      1: nWr = 1;
      default: nAck = 1;
    endcase
    cycles = 0; extraReady = 0;
    while (cycles < 60) begin
      @(posedge clk); cycles++;
      @(negedge clk);
      if (nReady) break;
    end
    repeat (holdExtra) begin
      @(negedge clk);
      if (nReady) extraReady++;
    end
    nRd = 0; nWr = 0; nAck = 0;
    @(negedge clk);
  endtask

  task automatic testReset();
    check(!nReady && nIorqN && nRdN && nM1N && nCeN == 1'b1 && !nOe, "R1 idle outputs",
          {nReady, nIorqN, nRdN, nM1N, nCeN, nOe}, 6'b011110);
    check(nRdData == 8'h00, "R1 read data reset", nRdData, 0);
  endtask

  task automatic testWriteRead();
    int c, x;
    access(1, 16'h0211, 8'h3C, 0, c, x);
    check(c == 5, "R6 write ready timing", c, 5);
    check(regs[1] == 8'h3C, "R4 write stored", regs[1], 8'h3C);
    check(iorqLen == 4, "R4 write iorq length", iorqLen, 4);
    access(1, 16'h0213, 8'hA7, 0, c, x);
    check(regs[3] == 8'hA7 && regs[1] == 8'h3C, "R2 channel select", regs[3], 8'hA7);
    access(0, 16'h0211, 8'h00, 0, c, x);
    check(c == 5, "R6 read ready timing", c, 5);
    check(nRdData == 8'h3C, "R3 read data", nRdData, 8'h3C);
    check(iorqLen == 4, "R3 read iorq length", iorqLen, 4);
    check(!nReady && nIorqN && nCeN == 1'b1, "R1 quiet after access", nIorqN, 1);
  endtask

  task automatic testAck();
    int c, x;
    access(2, 16'h0000, 8'h00, 0, c, x);
    check(c == 5, "R5 ack timing", c, 5);
    check(nRdData == 8'h1C, "R5 vector returned", nRdData, 8'h1C);
    check(!ackRdBad && !ackCeBad, "R5 ack without RD or CE", {ackRdBad, ackCeBad}, 0);
  endtask

  task automatic testUnmapped();
    int c, x, ev;
    ev = busEvents;
    access(0, 16'h0214, 8'h00, 0, c, x);
    check(c == 1, "R2 unmapped read timing", c, 1);
    check(nRdData == 8'hFF, "R2 unmapped read data", nRdData, 8'hFF);
    access(1, 16'h0250, 8'h99, 0, c, x);
    check(c == 1, "R2 unmapped write timing", c, 1);
    check(busEvents == ev, "R2 no peripheral cycle", busEvents, ev);
  endtask

  task automatic testWide();
    int c;
    @(negedge clk);
    hostAddr = 16'h0215; wRd = 1;
    c = 0;
    while (c < 60) begin
      @(posedge clk); c++;
      @(negedge clk);
      if (wReady) break;
    end
    wRd = 0;
    @(negedge clk);
    check(c == 17, "R6 two-chip wait timing", c, 17);
    check(wRdData == 8'h5A, "R3 two-chip read data", wRdData, 8'h5A);
    check(wCe1Seen && !wCe0Seen, "R2 upper chip enable", {wCe1Seen, wCe0Seen}, 2'b10);
  endtask

  task automatic testReti();
    int c, x, f, r;
    f = fetchCount; r = retiCount;
    access(1, 16'h0260, 8'hED, 0, c, x);
    check(c == 5 && lastFetch == 8'hED, "R7 fetch with byte", lastFetch, 8'hED);
    access(1, 16'h0260, 8'h4D, 0, c, x);
    check(retiCount == r + 1, "R8 clean pair", retiCount, r + 1);
    check(fetchCount == f + 2, "R7 one fetch per write", fetchCount, f + 2);
    access(1, 16'h0260, 8'h4D, 0, c, x);
    check(retiCount == r + 1, "R8 lone 4D", retiCount, r + 1);
    access(1, 16'h0260, 8'hED, 0, c, x);
    access(1, 16'h0260, 8'h11, 0, c, x);
    access(1, 16'h0260, 8'h4D, 0, c, x);
    check(retiCount == r + 1, "R8 broken pair", retiCount, r + 1);
    access(1, 16'h0260, 8'hED, 0, c, x);
    access(1, 16'h0260, 8'h4D, 0, c, x);
    check(retiCount == r + 2, "R8 second pair", retiCount, r + 2);
  endtask

  task automatic testHold();
    int c, x, ev;
    access(0, 16'h0210, 8'h00, 0, c, x);
    ev = busEvents;
    access(0, 16'h0212, 8'h00, 12, c, x);
    check(x == 0, "R9 no second ready", x, 0);
    check(busEvents == ev + 1, "R9 single peripheral cycle", busEvents, ev + 1);
    access(0, 16'h0212, 8'h00, 0, c, x);
    check(c == 5, "R9 next access after drop", c, 5);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testWriteRead();
    testAck();
    testUnmapped();
    testWide();
    testReti();
    testHold();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule